// File: doc/BRIEF.md
# Asynchronous FIFO Bus Master Sequencer

This block is the master-side waveform engine for an external FIFO peripheral that has no clock of its own. It moves bytes over an 8-bit bus using an active-low read strobe, an active-low write strobe, an active-low packet-end strobe and a 2-bit FIFO select. A trigger carries a direction and a byte count. The engine then runs one fixed micro-sequence per byte. It first checks the peripheral flag that matters for the direction. It then holds the strobe low for a set number of cycles, and finally captures the read byte or advances the write source. Between strobes it keeps a recovery gap.

The peripheral's not-empty and not-full flags pass through a synchronizer before use. The sequence does not wait for a flag that reports no room or no data. It aborts the transaction and raises a one-cycle interrupt. A write burst shorter than the maximum packet size ends with a single packet-end pulse while the engine is idle again. A read always asks for a fixed full-packet count. If it is cut short by an empty peripheral, the engine reports the bytes it has gathered as a short packet to commit. The internal source and sink buffers are plain per-byte handshakes.

Top module: `afm_seq_top`

## Requirements
- R1: While reset is held and right after it, done_o=1, rd_n_o=1, wr_n_o=1, pktend_n_o=1, irq_o=0, bus_oe_o=0 and fsel_o=2'b00.
- R2: A trigger (start_i=1) is accepted only while done_o=1. For any accepted trigger other than a zero-count write, done_o is 0 in the following cycle. Triggers seen while done_o=0 change nothing.
- R3: Before each byte the engine checks a ready flag that has passed through a two-stage synchronizer. A read checks rdy_nempty_i (1 = peripheral holds data) and a write checks rdy_nfull_i (1 = peripheral has room). A strobe is asserted only after a true check.
- R4: Each strobe stays low for exactly STROBE_CYC cycles (default 3). The read and write strobes are never low together.
- R5: Between two strobes of one transaction both strobe lines stay high for at least 3 cycles.
- R6: During a write byte, bus_oe_o=1 and bus_out_o holds the source byte from the cycle the write strobe falls through the cycle it rises. src_adv_o pulses exactly once per byte, in the cycle the write strobe rises.
- R7: A read byte is captured from bus_in_i in the last strobe-low cycle. It is presented on sink_data_o with sink_valid_o=1 in the cycle the read strobe rises.
- R8: A write moves count_i bytes. A read requests RD_COUNT bytes (default 512), whatever count_i holds.
- R9: A false flag at the check step gives a one-cycle irq_o pulse with no strobe. done_o returns to 1 in the next cycle.
- R10: A write with count_i < MAX_PKT (default 512) that ends without abort, including count 0, drives pktend_n_o low for exactly one cycle, in a cycle where done_o=1. A full-size write or an aborted write gives no pulse.
- R11: A read aborted after at least one byte pulses rd_commit_o once, with rd_len_o equal to the bytes received. A read of zero bytes or of the full count gives no pulse.
- R12: fsel_o is set on each accepted trigger: 2'b10 for a write (dir_i=0) and 2'b00 for a read (dir_i=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transaction trigger |
| dir_i | input | 1 | 0 = write to peripheral, 1 = read from peripheral |
| count_i | input | CNT_W | Write byte count |
| done_o | output | 1 | Engine idle, ready for a trigger |
| irq_o | output | 1 | Abort interrupt pulse |
| rdy_nempty_i | input | 1 | Asynchronous peripheral not-empty flag |
| rdy_nfull_i | input | 1 | Asynchronous peripheral not-full flag |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| pktend_n_o | output | 1 | Active-low packet-end strobe |
| fsel_o | output | 2 | Peripheral FIFO select |
| bus_out_o | output | DATA_W | Write data toward the peripheral |
| bus_oe_o | output | 1 | Output enable for bus_out_o |
| bus_in_i | input | DATA_W | Read data from the peripheral |
| src_data_i | input | DATA_W | Current byte of the internal write source |
| src_adv_o | output | 1 | Advance the write source pointer |
| sink_data_o | output | DATA_W | Byte read from the peripheral |
| sink_valid_o | output | 1 | sink_data_o is valid this cycle |
| rd_commit_o | output | 1 | Commit a short read packet |
| rd_len_o | output | CNT_W | Byte count of the short read packet |

## Verification
- done_o falls one cycle after an accepted trigger.
- A flag change takes two cycles to reach the check step.
- The strobe is low for three cycles. src_adv_o or sink_valid_o then appear in the very cycle the strobe returns high.
- irq_o comes one cycle after a failed check, and done_o rises one cycle after irq_o.
- The packet-end pulse falls in the first cycle done_o is high again.

The bench drives inputs and samples outputs on the falling edge. A monitor then sees each registered result half a cycle after the edge that produced it. Widths, gaps and pulse coincidences are counted per cycle rather than timed from the trigger. This keeps every check tied to the cycle in which the result is due.

// File: rtl/afm_pkg.sv
package afm_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_LOW, S_SAMP, S_GAP, S_ABT, S_PKE
  } afm_state_e;

  localparam logic [1:0] SEL_WR = 2'b10;
  localparam logic [1:0] SEL_RD = 2'b00;
endpackage

// File: rtl/afm_sync.sv
module afm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= '0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/afm_down_cnt.sv
module afm_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (rst)       val <= '0;
    else if (load) val <= load_val;
    else if (dec)  val <= val - 1'b1;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> (val != '0)); // R8
endmodule

// File: rtl/afm_seq_top.sv
module afm_seq_top #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 10,
  parameter int MAX_PKT     = 512,
  parameter int RD_COUNT    = 512,
  parameter int STROBE_CYC  = 3,
  parameter int GAP_CYC     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              done_o,
  output logic              irq_o,
  input  logic              rdy_nempty_i,
  input  logic              rdy_nfull_i,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              pktend_n_o,
  output logic [1:0]        fsel_o,
  output logic [DATA_W-1:0] bus_out_o,
  output logic              bus_oe_o,
  input  logic [DATA_W-1:0] bus_in_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_adv_o,
  output logic [DATA_W-1:0] sink_data_o,
  output logic              sink_valid_o,
  output logic              rd_commit_o,
  output logic [CNT_W-1:0]  rd_len_o
);
  import afm_pkg::*;

  localparam int TMR_MAX = (STROBE_CYC > GAP_CYC) ? STROBE_CYC : GAP_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [CNT_W-1:0] RD_LEN = CNT_W'(RD_COUNT);

  afm_state_e       st, nst;
  logic             dir_q, short_q, dir_d, accept;
  logic             ne_s, nf_s, flag_ok;
  logic             rem_ld, rem_dec, tmr_ld, tmr_dec;
  logic [CNT_W-1:0] rem, ld_val;
  logic [TMR_W-1:0] tmr, tmr_val;
  logic             start_short;

  afm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({rdy_nempty_i, rdy_nfull_i}),
    .q({ne_s, nf_s})
  );

  afm_down_cnt #(.W(CNT_W)) u_rem (
    .clk(clk), .rst(rst), .load(rem_ld), .dec(rem_dec),
    .load_val(ld_val), .val(rem)
  );

  afm_down_cnt #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_ld), .dec(tmr_dec),
    .load_val(tmr_val), .val(tmr)
  );

  assign ld_val      = dir_i ? RD_LEN : count_i;
  assign start_short = !dir_i && (int'(count_i) < MAX_PKT);
  assign flag_ok     = dir_q ? ne_s : nf_s;
  assign dir_d       = accept ? dir_i : dir_q;

  always_comb begin
    nst     = st;
    accept  = 1'b0;
    rem_ld  = 1'b0;
    rem_dec = 1'b0;
    tmr_ld  = 1'b0;
    tmr_dec = 1'b0;
    tmr_val = '0;
    unique case (st)
      S_IDLE, S_PKE: begin
        nst = S_IDLE;
        if (start_i) begin
          accept = 1'b1;
          rem_ld = 1'b1;
          if (ld_val == '0) nst = start_short ? S_PKE : S_IDLE;
          else              nst = S_CHK;
        end
      end
      S_CHK: begin
        if (flag_ok) begin
          nst     = S_LOW;
          tmr_ld  = 1'b1;
          tmr_val = TMR_W'(STROBE_CYC - 1);
        end else begin
          nst = S_ABT;
        end
      end
      S_LOW: begin
        if (tmr == '0) nst = S_SAMP;
        else           tmr_dec = 1'b1;
      end
      S_SAMP: begin
        rem_dec = 1'b1;
        if (rem == CNT_W'(1)) begin
          nst = short_q ? S_PKE : S_IDLE;
        end else begin
          nst     = S_GAP;
          tmr_ld  = 1'b1;
          tmr_val = TMR_W'(GAP_CYC - 1);
        end
      end
      S_GAP: begin
        if (tmr == '0) nst = S_CHK;
        else           tmr_dec = 1'b1;
      end
      S_ABT:   nst = S_IDLE;
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      dir_q        <= 1'b0;
      short_q      <= 1'b0;
      done_o       <= 1'b1;
      irq_o        <= 1'b0;
      rd_n_o       <= 1'b1;
      wr_n_o       <= 1'b1;
      pktend_n_o   <= 1'b1;
      fsel_o       <= SEL_RD;
      bus_out_o    <= '0;
      bus_oe_o     <= 1'b0;
      src_adv_o    <= 1'b0;
      sink_data_o  <= '0;
      sink_valid_o <= 1'b0;
      rd_commit_o  <= 1'b0;
      rd_len_o     <= '0;
    end else begin
      st <= nst;
      if (accept) begin
        dir_q   <= dir_i;
        short_q <= start_short;
        fsel_o  <= dir_i ? SEL_RD : SEL_WR;
      end
      done_o       <= (nst == S_IDLE) || (nst == S_PKE);
      irq_o        <= (nst == S_ABT);
      rd_n_o       <= !((nst == S_LOW) && dir_d);
      wr_n_o       <= !((nst == S_LOW) && !dir_d);
      pktend_n_o   <= !(nst == S_PKE);
      bus_oe_o     <= ((nst == S_LOW) || (nst == S_SAMP)) && !dir_d;
      src_adv_o    <= (nst == S_SAMP) && !dir_d;
      sink_valid_o <= (nst == S_SAMP) && dir_d;
      rd_commit_o  <= (nst == S_ABT) && dir_q && (rem != RD_LEN);
      if (nst == S_ABT) rd_len_o <= RD_LEN - rem;
      if ((st == S_CHK) && (nst == S_LOW) && !dir_q) bus_out_o <= src_data_i;
      if ((st == S_LOW) && (nst == S_SAMP) && dir_q) sink_data_o <= bus_in_i;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n_o && !wr_n_o)); // R4
  AST_RD_AFTER_FLAG: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n_o) |-> $past(ne_s)); // R3
  AST_WR_AFTER_FLAG: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n_o) |-> $past(nf_s)); // R3
  AST_ABORT_FROM_CHECK: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(st == S_CHK)); // R9
  AST_PKTEND_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pktend_n_o |-> done_o); // R10
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    (done_o && start_i && (dir_i || count_i != '0)) |=> !done_o); // R2
  AST_OE_WRITE_SEL: assert property (@(posedge clk) disable iff (rst)
    bus_oe_o |-> (fsel_o == SEL_WR)); // R12
endmodule

// File: tb/afm_seq_top_tb.sv
module afm_seq_top_tb_top;
  localparam int DW = 8;
  localparam int CW = 10;

  typedef struct packed {
    logic        dir;
    logic [9:0]  cnt;
    logic [10:0] depth;
    logic [9:0]  bytes;
    logic        irq;
    logic        pkt;
    logic        com;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'd4,   11'd100, 10'd4,   1'b0, 1'b1, 1'b0},
    '{1'b0, 10'd512, 11'd600, 10'd512, 1'b0, 1'b0, 1'b0},
    '{1'b0, 10'd10,  11'd6,   10'd6,   1'b1, 1'b0, 1'b0},
    '{1'b0, 10'd0,   11'd5,   10'd0,   1'b0, 1'b1, 1'b0},
    '{1'b1, 10'd7,   11'd600, 10'd512, 1'b0, 1'b0, 1'b0},
    '{1'b1, 10'd0,   11'd37,  10'd37,  1'b1, 1'b0, 1'b1},
    '{1'b1, 10'd3,   11'd0,   10'd0,   1'b1, 1'b0, 1'b0},
    '{1'b0, 10'd1,   11'd0,   10'd0,   1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0, dir_i = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic done_o, irq_o, rd_n_o, wr_n_o, pktend_n_o, bus_oe_o;
  logic src_adv_o, sink_valid_o, rd_commit_o;
  logic [1:0] fsel_o;
  logic [DW-1:0] bus_out_o, bus_in_i, src_data_i, sink_data_o;
  logic [CW-1:0] rd_len_o;

  int wr_total = 0, rd_total = 0, adv_total = 0, sink_total = 0;
  int wr_limit = 0, rd_limit = 0;
  int pkt_low = 0, irq_total = 0, com_total = 0, com_len = 0;
  int width_err = 0, gap_err = 0, wdata_err = 0, rdata_err = 0, abort_err = 0;
  int low_run = 0, hi_run = 100;
  logic prev_wr = 1'b1, prev_rd = 1'b1, prev_irq = 1'b0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] wbyte(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] rbyte(input int k);
    return 8'(((k * 13 + 5) & 255) ^ 8'hA5);
  endfunction

  assign src_data_i = wbyte(adv_total);
  assign bus_in_i   = rbyte(rd_total);

  afm_seq_top dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .dir_i(dir_i), .count_i(count_i),
    .done_o(done_o), .irq_o(irq_o),
    .rdy_nempty_i(rd_total < rd_limit), .rdy_nfull_i(wr_total < wr_limit),
    .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .pktend_n_o(pktend_n_o), .fsel_o(fsel_o),
    .bus_out_o(bus_out_o), .bus_oe_o(bus_oe_o), .bus_in_i(bus_in_i),
    .src_data_i(src_data_i), .src_adv_o(src_adv_o),
    .sink_data_o(sink_data_o), .sink_valid_o(sink_valid_o),
    .rd_commit_o(rd_commit_o), .rd_len_o(rd_len_o)
  );

  // peripheral, buffer and timing monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      logic any_low, rise_wr, rise_rd;
      any_low = !rd_n_o || !wr_n_o;
      rise_wr = !prev_wr && wr_n_o;
      rise_rd = !prev_rd && rd_n_o;
      if (!rd_n_o && !wr_n_o) width_err++;
      if (any_low) begin
        if (low_run == 0 && hi_run < 3) gap_err++;
        low_run++;
        hi_run = 0;
      end else begin
        if (low_run != 0 && low_run != 3) width_err++;
        low_run = 0;
        hi_run++;
      end
      if (!wr_n_o || rise_wr)
        if (!bus_oe_o || bus_out_o != wbyte(wr_total)) wdata_err++;
      if (src_adv_o != rise_wr) wdata_err++;
      if (src_adv_o) adv_total++;
      if (rise_wr) wr_total++;
      if (sink_valid_o != rise_rd) rdata_err++;
      if (sink_valid_o) begin
        if (sink_data_o != rbyte(sink_total)) rdata_err++;
        sink_total++;
      end
      if (rise_rd) rd_total++;
      if (irq_o) begin
        irq_total++;
        if (any_low || done_o) abort_err++;
      end
      if (prev_irq && !done_o) abort_err++;
      if (!pktend_n_o) begin
        pkt_low++;
        if (!done_o) pkt_low += 1000;
      end
      if (rd_commit_o) begin
        com_total++;
        com_len = int'(rd_len_o);
      end
      prev_wr  = wr_n_o;
      prev_rd  = rd_n_o;
      prev_irq = irq_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic d, input logic [CW-1:0] c);
    dir_i = d; count_i = c; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int b_wr, b_sink, b_adv, b_pkt, b_irq, b_com;
    b_wr = wr_total; b_sink = sink_total; b_adv = adv_total;
    b_pkt = pkt_low; b_irq = irq_total; b_com = com_total;
    if (v.dir) rd_limit = rd_total + int'(v.depth);
    else       wr_limit = wr_total + int'(v.depth);
    repeat (4) @(negedge clk);
    pulse_start(v.dir, v.cnt);
    chk(done_o == (!v.dir && v.cnt == 0), "R2 done after trigger", done_o, !v.dir && v.cnt == 0);
    chk(fsel_o == (v.dir ? 2'b00 : 2'b10), "R12 fifo select", fsel_o, v.dir ? 0 : 2);
    wait_done();
    if (v.dir) begin
      chk(sink_total - b_sink == int'(v.bytes), "R7 R8 read bytes", sink_total - b_sink, v.bytes);
    end else begin
      chk(wr_total - b_wr == int'(v.bytes), "R8 write bytes", wr_total - b_wr, v.bytes);
      chk(adv_total - b_adv == int'(v.bytes), "R6 source advances", adv_total - b_adv, v.bytes);
    end
    chk(irq_total - b_irq == int'(v.irq), "R9 abort irq", irq_total - b_irq, v.irq);
    chk(pkt_low - b_pkt == int'(v.pkt), "R10 packet end", pkt_low - b_pkt, v.pkt);
    chk(com_total - b_com == int'(v.com), "R11 commit pulses", com_total - b_com, v.com);
    if (v.com) chk(com_len == int'(v.bytes), "R11 commit length", com_len, v.bytes);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(done_o == 1'b1, "R1 reset done", done_o, 1);
    chk(rd_n_o && wr_n_o, "R1 reset strobes", {rd_n_o, wr_n_o}, 3);
    chk(pktend_n_o == 1'b1, "R1 reset packet end", pktend_n_o, 1);
    chk(irq_o == 1'b0, "R1 reset irq", irq_o, 0);
    chk(bus_oe_o == 1'b0, "R1 reset bus enable", bus_oe_o, 0);
    chk(fsel_o == 2'b00, "R1 reset select", fsel_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done_o && rd_n_o && wr_n_o, "R1 after reset idle", done_o, 1);

    // table-driven transactions
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R2: a trigger while busy is ignored
    begin
      int b_wr, b_rd;
      b_wr = wr_total; b_rd = rd_total;
      wr_limit = wr_total + 100; rd_limit = rd_total + 100;
      repeat (4) @(negedge clk);
      pulse_start(1'b0, 10'd3);
      repeat (3) @(negedge clk);
      chk(done_o == 1'b0, "R2 busy mid write", done_o, 0);
      pulse_start(1'b1, 10'd9);
      chk(fsel_o == 2'b10, "R2 busy trigger select", fsel_o, 2);
      wait_done();
      chk(wr_total - b_wr == 3, "R2 busy trigger write bytes", wr_total - b_wr, 3);
      chk(rd_total - b_rd == 0, "R2 busy trigger no read", rd_total - b_rd, 0);
      chk(fsel_o == 2'b10, "R12 select kept", fsel_o, 2);
      rd_limit = rd_total;
    end

    chk(width_err == 0, "R4 strobe low width", width_err, 0);
    chk(gap_err == 0, "R5 strobe high gap", gap_err, 0);
    chk(wdata_err == 0, "R6 write data window", wdata_err, 0);
    chk(rdata_err == 0, "R7 read capture", rdata_err, 0);
    chk(abort_err == 0, "R9 abort timing", abort_err, 0);
    chk(pkt_low < 1000, "R10 packet end while idle", pkt_low, 0);
    // R3: flags were honoured, no strobe past the peripheral's limits
    chk(wr_total <= wr_limit, "R3 no write past full", wr_total, wr_limit);
    chk(rd_total <= rd_limit, "R3 no read past empty", rd_total, rd_limit);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule